// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which physical frame should be given up when a new page must be brought in. It keeps one "recently used" bit per frame and a circular hand pointer. Whenever the memory system reports that a frame was used, that frame's bit is set. When a replacement is requested, the hand walks the frames one per clock cycle. A frame whose bit is set loses the bit and is passed over. The first frame found with its bit clear becomes the victim. This approximates least-recently-used replacement without keeping any full ordering of the frames.

The requester raises `req_valid` and holds it until it sees `gnt_valid`. The grant is a single-cycle pulse that carries the victim index on `gnt_frame`. The grant cannot be back-pressured: the requester must capture the index in the pulse cycle, and it drops or re-raises `req_valid` afterwards. While a grant pulse is on the output, no new examination starts. Access notifications are a plain valid strobe with no ready signal. They are always accepted, one per cycle.

Top module: `clock_victim_sel`

## Requirements
- R1: Asynchronous active-low reset clears every frame's bit, puts the hand on frame 0 and holds `gnt_valid` low. A request issued right after reset is granted frame 0.
- R2: An access notification with `acc_valid` high sets the bit of frame `acc_frame` from the next cycle on.
- R3: While `req_valid` is high and no grant pulse is out, one frame is examined per cycle, starting at the hand and going upward with wrap from frame N-1 to 0. A frame with its bit set has the bit cleared and is skipped, and the hand advances by one.
- R4: The first examined frame with its bit clear is granted. `gnt_valid` is high for exactly one cycle, the cycle after the examination, and `gnt_frame` holds that frame's 4-bit index.
- R5: After a grant the hand points one frame past the victim (modulo N), and the victim's bit is set.
- R6: With no access notifications during the sweep, a grant appears within N+1 cycles of a held request (17 cycles for 16 frames).
- R7: If an access names the frame being examined in the same cycle, the access wins. The bit stays set, that frame is skipped and the hand advances.
- R8: While `req_valid` is low the hand does not move and no bit is cleared. Only accesses change state.
- R9: `gnt_valid` is never raised unless `req_valid` was high in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access notification strobe |
| acc_frame | input | 4 | Index of the frame that was used |
| req_valid | input | 1 | Victim request, held until the grant |
| gnt_valid | output | 1 | One-cycle victim grant pulse |
| gnt_frame | output | 4 | Victim frame index, valid with gnt_valid |

## Verification
An access notification and the sweep can act in the same cycle. Either can touch the frame under the hand, and an access can also land on a frame at the moment that frame is granted. The directed part forces the first case by raising an access to the hand's frame in the first cycle of a request. It then shows that the frame was skipped and that its bit survived: a later full lap passes over that frame again. The random part strobes accesses in about half of all cycles while requests are outstanding. Every cycle it compares the grant pulse and index with a bench model that lets the access win over the sweep.

// File: rtl/cvs_pkg.sv
`timescale 1ns/1ps
package cvs_pkg;
  localparam int unsigned DEF_FRAMES = 16;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_SKIP = 2'd1,
    SCAN_PICK = 2'd2
  } scan_act_e;
endpackage

// File: rtl/cvs_ref_bits.sv
`timescale 1ns/1ps
module cvs_ref_bits #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          pick_en,
  input  logic          clr_en,
  input  logic [IW-1:0] hand,
  output logic [N-1:0]  bits
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit_acc, hit_hand;
    assign hit_acc  = acc_valid && (acc_frame == IW'(g));
    assign hit_hand = (hand == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bits[g] <= 1'b0;
      else if (hit_acc || (pick_en && hit_hand))
        bits[g] <= 1'b1;
      else if (clr_en && hit_hand)
        bits[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/cvs_hand.sv
`timescale 1ns/1ps
module cvs_hand #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] hand
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] hand_nxt;
  assign hand_nxt = (hand == LAST) ? '0 : hand + IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hand <= '0;
    else if (adv) hand <= hand_nxt;
  end
endmodule

// File: rtl/cvs_scan.sv
`timescale 1ns/1ps
module cvs_scan
  import cvs_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          req_valid,
  input  logic          gnt_busy,
  input  logic [N-1:0]  bits,
  input  logic [IW-1:0] hand,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  output scan_act_e     act,
  output logic          clr_en
);
  logic active, acc_on_hand, seen_used;

  assign active      = req_valid && !gnt_busy;
  assign acc_on_hand = acc_valid && (acc_frame == hand);
  assign seen_used   = bits[hand] || acc_on_hand;

  always_comb begin
    act = SCAN_IDLE;
    if (active) act = seen_used ? SCAN_SKIP : SCAN_PICK;
  end

  // a same-cycle access to the examined frame keeps its bit
  assign clr_en = (act == SCAN_SKIP) && !acc_on_hand;
endmodule

// File: rtl/clock_victim_sel.sv
`timescale 1ns/1ps
module clock_victim_sel
  import cvs_pkg::*;
#(
  parameter int unsigned N  = DEF_FRAMES,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          req_valid,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_frame
);
  logic [N-1:0]  ref_bits;
  logic [IW-1:0] hand;
  scan_act_e     act;
  logic          clr_en, pick_en, adv;

  assign pick_en = (act == SCAN_PICK);
  assign adv     = (act != SCAN_IDLE);

  cvs_scan #(.N(N), .IW(IW)) u_scan (
    .req_valid (req_valid),
    .gnt_busy  (gnt_valid),
    .bits      (ref_bits),
    .hand      (hand),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .act       (act),
    .clr_en    (clr_en)
  );

  cvs_ref_bits #(.N(N), .IW(IW)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .pick_en   (pick_en),
    .clr_en    (clr_en),
    .hand      (hand),
    .bits      (ref_bits)
  );

  cvs_hand #(.N(N), .IW(IW)) u_hand (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .hand  (hand)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_frame <= '0;
    end else begin
      gnt_valid <= pick_en;
      if (pick_en) gnt_frame <= hand;
    end
  end
endmodule

// File: rtl/cvs_checker.sv
`timescale 1ns/1ps
module cvs_checker #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [IW-1:0] acc_frame,
  input logic          req_valid,
  input logic          gnt_valid,
  input logic [IW-1:0] gnt_frame,
  input logic [IW-1:0] hand,
  input logic [N-1:0]  ref_bits
);
  localparam int unsigned CW = IW + 2;
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (!req_valid || gnt_valid || acc_valid) wait_cnt <= '0;
    else wait_cnt <= wait_cnt + CW'(1);
  end

  p_gnt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid);

  p_gnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $past(req_valid));

  p_victim_was_hand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_frame == $past(hand));

  p_hand_past_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> hand == ((gnt_frame == IW'(N - 1)) ? '0 : gnt_frame + IW'(1)));

  p_victim_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ref_bits[gnt_frame]);

  p_access_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_bits[$past(acc_frame)]);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> hand == $past(hand));

  p_sweep_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CW'(N + 1));
endmodule

bind clock_victim_sel cvs_checker #(.N(N), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_frame (acc_frame),
  .req_valid (req_valid),
  .gnt_valid (gnt_valid),
  .gnt_frame (gnt_frame),
  .hand      (hand),
  .ref_bits  (ref_bits)
);

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;
  localparam int NF = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [3:0] acc_frame = '0;
  logic       req_valid = 1'b0;
  logic       gnt_valid;
  logic [3:0] gnt_frame;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  bit       m_bits [NF];
  int       m_hand;
  bit       m_gv;
  bit       exp_gv;
  int       exp_gf;

  always #2 clk = ~clk;

  clock_victim_sel dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .req_valid(req_valid), .gnt_valid(gnt_valid), .gnt_frame(gnt_frame)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // next-state rules from the requirements: access beats the sweep
  task automatic model_step(input bit r, input bit av, input int af);
    exp_gv = 1'b0;
    if (r && !m_gv) begin
      if (m_bits[m_hand] || (av && af == m_hand)) begin
        m_bits[m_hand] = av && (af == m_hand);
      end else begin
        exp_gv = 1'b1;
        exp_gf = m_hand;
        m_bits[m_hand] = 1'b1;
      end
      m_hand = (m_hand + 1) % NF;
    end
    if (av) m_bits[af] = 1'b1;
    m_gv = exp_gv;
  endtask

  task automatic cycle(input bit r, input bit av, input int af);
    @(negedge clk);
    req_valid = r; acc_valid = av; acc_frame = 4'(af);
    model_step(r, av, af);
    @(posedge clk); #1;
    chk(gnt_valid === exp_gv, "R4 grant pulse", int'(gnt_valid), int'(exp_gv));
    if (exp_gv)
      chk(int'(gnt_frame) == exp_gf, "R4 grant index", int'(gnt_frame), exp_gf);
  endtask

  task automatic request(input bit av0, input int af0, output int frame, output int lat);
    lat = 0; frame = -1;
    for (int k = 0; k < 40; k++) begin
      cycle(1'b1, (k == 0) ? av0 : 1'b0, af0);
      lat++;
      if (gnt_valid === 1'b1) begin
        frame = int'(gnt_frame);
        break;
      end
    end
    cycle(1'b0, 1'b0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int f, lat;
    bool_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(gnt_valid === 1'b0, "R1 idle after reset", int'(gnt_valid), 0);

    request(1'b0, 0, f, lat);
    chk(f == 0 && lat == 1, "R1 first victim is frame 0", f * 100 + lat, 1);
    request(1'b0, 0, f, lat);
    chk(f == 1, "R5 hand past previous victim", f, 1);

    cycle(1'b0, 1'b1, 2);
    cycle(1'b0, 1'b1, 3);
    request(1'b0, 0, f, lat);
    chk(f == 4, "R2 accessed frames skipped", f, 4);
    chk(lat == 3, "R3 one frame per cycle", lat, 3);

    for (int i = 0; i < NF; i++) cycle(1'b0, 1'b1, i);
    request(1'b0, 0, f, lat);
    chk(f == 5, "R6 full lap returns to start", f, 5);
    chk(lat == NF + 1, "R6 bounded sweep latency", lat, NF + 1);

    request(1'b1, 6, f, lat);
    chk(f == 7 && lat == 2, "R7 same-cycle access skips frame", f * 100 + lat, 702);

    for (int i = 0; i < 5; i++) begin
      cycle(1'b0, 1'b1, 9);
      chk(gnt_valid === 1'b0, "R9 no grant without request", int'(gnt_valid), 0);
    end
    request(1'b0, 0, f, lat);
    chk(f == 8 && lat == 1, "R8 hand held while idle", f * 100 + lat, 801);
    request(1'b0, 0, f, lat);
    chk(f == 10, "R2 idle access marked frame 9", f, 10);

    for (int i = 0; i < 10; i++) begin
      request(1'b0, 0, f, lat);
      chk(f == (11 + i) % NF, "R3 circular order with wrap", f, (11 + i) % NF);
    end
    request(1'b0, 0, f, lat);
    chk(f == 9 && lat == 5, "R7 contested bit survived", f * 100 + lat, 905);

    begin
      bit pend = 1'b0;
      void'($urandom(32'h5eed_c10c));
      for (int c = 0; c < 4000; c++) begin
        bit r, av;
        if (!pend) pend = ($urandom % 3) == 0;
        r  = pend;
        av = ($urandom % 2) == 0;
        cycle(r, av, int'($urandom % NF));
        if (gnt_valid === 1'b1) pend = 1'b0;
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  task automatic bool_init();
    for (int i = 0; i < NF; i++) m_bits[i] = 1'b0;
    m_hand = 0; m_gv = 1'b0; exp_gv = 1'b0; exp_gf = 0;
  endtask
endmodule